// File: doc/BRIEF.md
# Virtual Probe and Stimulus Port

A debug core that gives a slow host register interface control over design inputs and visibility into design outputs. It offers four probe ports: an asynchronous output (`aout`) straight from a host-clocked register, meant for design inputs with no timing demands such as resets; an asynchronous input (`ain`) that the host domain synchronizes and samples; a synchronous output (`sout`) that changes only on the design clock; and a synchronous input (`sin`) sampled on every design clock edge.

The synchronous output can play a pulse train. The host loads sixteen step words, one bit per output line, and then issues a start command. The core drives the sixteen steps on consecutive design clocks. It then falls back to the static value the host last wrote. Host-to-design traffic (static value, start, activity clear) crosses domains with toggle handshakes. Each input has sticky rising and falling activity flags, so an edge is not lost between two slow host reads. A host read returns a single snapshot and is not a capture stream.

The host side uses plain strobes. `host_wr` commits on the `hclk` edge where it is high. `host_rd` returns `host_rdata` with a one-cycle `host_rvalid` on the next edge. There is no back-pressure, so the host may issue one access per cycle.

Top module: `virt_probe_port`

## Requirements
- R1: After reset, `aout` and `sout` are zero, `host_rvalid` is low, and reads of the control word (address 2, bit 0 = busy) and both activity words (addresses 5 and 6) return zero.
- R2: A write to address 0 sets `aout` on the same `hclk` edge. `aout` holds its value at all other times.
- R3: A write to address 1 stores the static synchronous value. Outside playback, `sout` shows this value from the fourth `dclk` edge after the write edge when both clocks share one edge (two synchronizer stages, one detect stage, one output register).
- R4: Addresses 16..31 hold steps 0..15 of the pattern, with step index = address bits [3:0]. Writing 1 to address 2 bit 0 starts playback. When the clocks share edges, `sout` equals step k from the (3+k)-th `dclk` edge after the write edge, for k = 0..15. From the 19th edge on it equals the static value again.
- R5: Address 2 bit 0 reads 1 from the start write until playback has ended and been synchronized back. A start written while this bit is 1 is ignored.
- R6: Address 4 returns `sin` as sampled on `dclk`, passed through a two-flop synchronizer into `hclk`.
- R7: Address 6 holds the synchronous activity flags, with rising edges in bits [W-1:0] and falling edges in bits [2W-1:W]. A `sin` pulse that lasts a single `dclk` cycle sets both its rise and fall bits. The bits stay set until they are cleared.
- R8: Writing to address 6 clears the flags whose mask bits are 1 and leaves the others. An edge that arrives on the same `dclk` edge as the clear stays recorded.
- R9: Address 3 returns `ain` after a two-flop `hclk` synchronizer. Address 5 holds its activity flags in the R7 layout, cleared with write-1 masking on the write edge.
- R10: `host_rvalid` is high exactly on the cycle after `host_rd`, and `host_rdata` then holds the addressed word. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host register clock |
| dclk | input | 1 | Design clock for the synchronous ports |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | 5 | Register address |
| host_wdata | input | 2*W | Write data |
| host_rdata | output | 2*W | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| aout | output | W | Asynchronous stimulus output |
| ain | input | W | Asynchronous probe input |
| sout | output | W | Design-clocked stimulus output |
| sin | input | W | Design-clocked probe input |

## Verification
The bench drives both clocks from one source, which fixes every crossing latency. `aout` is due on the write edge itself. A static `sout` value is due four edges later. Pattern step k is due 3+k edges after the start write, and the static value returns at edge 19. The driver tags each expected `sout` word with its due cycle, and a monitor compares it against the output at the falling edge of that cycle. The bench reads flags and input values only after the synchronizer delays have passed. For the clear-collision case it places the `sin` change so that the edge detector and the clear pulse meet on the third edge after the write.

// File: rtl/vpp_pkg.sv
package vpp_pkg;
  localparam int ADDR_W   = 5;
  localparam int PT_STEPS = 16;

  localparam logic [ADDR_W-1:0] A_AOUT = 5'd0;
  localparam logic [ADDR_W-1:0] A_SVAL = 5'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 5'd2;
  localparam logic [ADDR_W-1:0] A_AIN  = 5'd3;
  localparam logic [ADDR_W-1:0] A_SIN  = 5'd4;
  localparam logic [ADDR_W-1:0] A_AACT = 5'd5;
  localparam logic [ADDR_W-1:0] A_SACT = 5'd6;
endpackage

// File: rtl/vpp_sync.sv
module vpp_sync #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] st1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= '0;
      q   <= '0;
    end else begin
      st1 <= d;
      q   <= st1;
    end
  end
endmodule

// File: rtl/vpp_tog_rx.sv
module vpp_tog_rx (
  input  logic clk,
  input  logic rst_n,
  input  logic tog,
  output logic pulse
);
  logic tog_s, tog_d;

  vpp_sync #(.N(1)) u_sync (.clk(clk), .rst_n(rst_n), .d(tog), .q(tog_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_d <= 1'b0;
    else        tog_d <= tog_s;
  end

  assign pulse = tog_s ^ tog_d;
endmodule

// File: rtl/vpp_edge_flags.sv
module vpp_edge_flags #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   sig,
  input  logic           clr,
  input  logic [2*W-1:0] clr_mask,
  output logic [W-1:0]   smp,
  output logic [2*W-1:0] flags
);
  logic [W-1:0]   rise, fall;
  logic [2*W-1:0] keep;

  assign rise = sig & ~smp;
  assign fall = ~sig & smp;
  assign keep = clr ? ~clr_mask : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp   <= '0;
      flags <= '0;
    end else begin
      smp   <= sig;
      flags <= (flags & keep) | {fall, rise};
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags))); // R7

  AST_EDGE_CAUGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (sig != smp) |=> (flags != '0)); // R8
endmodule

// File: rtl/vpp_player.sv
module vpp_player #(
  parameter int W     = 4,
  parameter int STEPS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sval_load,
  input  logic [W-1:0]     sval,
  input  logic [STEPS*W-1:0] pat,
  output logic [W-1:0]     sout,
  output logic             done_tog
);
  localparam int SW = $clog2(STEPS);
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  logic          run;
  logic [SW-1:0] step;
  logic [W-1:0]  sval_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      step     <= '0;
      sval_d   <= '0;
      sout     <= '0;
      done_tog <= 1'b0;
    end else begin
      if (sval_load) sval_d <= sval;
      if (run) begin
        sout <= pat[step*W +: W];
        step <= step + 1'b1;
        if (step == LAST) begin
          run      <= 1'b0;
          done_tog <= ~done_tog;
        end
      end else if (start) begin
        run  <= 1'b1;
        step <= SW'(1);
        sout <= pat[W-1:0];
      end else begin
        sout <= sval_d;
      end
    end
  end

  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step != LAST) |=> (run && step == $past(step) + 1'b1)); // R4

  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step == LAST) |=> (!run && done_tog != $past(done_tog))); // R5
endmodule

// File: rtl/virt_probe_port.sv
module virt_probe_port
  import vpp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic              hclk,
  input  logic              dclk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [2*W-1:0]    host_wdata,
  output logic [2*W-1:0]    host_rdata,
  output logic              host_rvalid,
  output logic [W-1:0]      aout,
  input  logic [W-1:0]      ain,
  output logic [W-1:0]      sout,
  input  logic [W-1:0]      sin
);
  localparam int DW    = 2 * W;
  localparam int STEPS = PT_STEPS;
  localparam int SW    = $clog2(STEPS);

  logic [W-1:0]       aout_r, sval_r;
  logic [W-1:0]       pat_r [STEPS];
  logic [STEPS*W-1:0] pat_flat;
  logic               start_tog, sval_tog, sclr_tog;
  logic [DW-1:0]      sclr_mask;
  logic               done_tog, done_s, busy;
  logic               start_p, sval_p, sclr_p, aclr;
  logic [W-1:0]       ain_s, ain_smp, sin_smp_d, sin_smp_h;
  logic [DW-1:0]      aact, sact_d, sact_h, rd_mux;

  assign busy = start_tog ^ done_s;
  assign aout = aout_r;
  assign aclr = host_wr && (host_addr == A_AACT);

  for (genvar k = 0; k < STEPS; k++) begin : g_pat
    assign pat_flat[k*W +: W] = pat_r[k];
  end

  always_ff @(posedge hclk or negedge rst_n) begin
    if (!rst_n) begin
      aout_r      <= '0;
      sval_r      <= '0;
      start_tog   <= 1'b0;
      sval_tog    <= 1'b0;
      sclr_tog    <= 1'b0;
      sclr_mask   <= '0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
      for (int k = 0; k < STEPS; k++) pat_r[k] <= '0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) host_rdata <= rd_mux;
      if (host_wr) begin
        if (host_addr[ADDR_W-1]) begin
          pat_r[host_addr[SW-1:0]] <= host_wdata[W-1:0];
        end else begin
          case (host_addr)
            A_AOUT: aout_r <= host_wdata[W-1:0];
            A_SVAL: begin
              sval_r   <= host_wdata[W-1:0];
              sval_tog <= ~sval_tog;
            end
            A_CTRL: if (host_wdata[0] && !busy) start_tog <= ~start_tog;
            A_SACT: begin
              sclr_mask <= host_wdata;
              sclr_tog  <= ~sclr_tog;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (host_addr[ADDR_W-1]) begin
      rd_mux[W-1:0] = pat_r[host_addr[SW-1:0]];
    end else begin
      case (host_addr)
        A_AOUT: rd_mux[W-1:0] = aout_r;
        A_SVAL: rd_mux[W-1:0] = sval_r;
        A_CTRL: rd_mux[0]     = busy;
        A_AIN:  rd_mux[W-1:0] = ain_smp;
        A_SIN:  rd_mux[W-1:0] = sin_smp_h;
        A_AACT: rd_mux        = aact;
        A_SACT: rd_mux        = sact_h;
        default: rd_mux = '0;
      endcase
    end
  end

  // host side: asynchronous input and its activity
  vpp_sync #(.N(W)) u_ain_sync (.clk(hclk), .rst_n(rst_n), .d(ain), .q(ain_s));

  vpp_edge_flags #(.W(W)) u_aact (
    .clk(hclk), .rst_n(rst_n), .sig(ain_s), .clr(aclr), .clr_mask(host_wdata),
    .smp(ain_smp), .flags(aact));

  // design side: synchronous input and its activity
  vpp_edge_flags #(.W(W)) u_sact (
    .clk(dclk), .rst_n(rst_n), .sig(sin), .clr(sclr_p), .clr_mask(sclr_mask),
    .smp(sin_smp_d), .flags(sact_d));

  vpp_sync #(.N(W))  u_sin_back  (.clk(hclk), .rst_n(rst_n), .d(sin_smp_d), .q(sin_smp_h));
  vpp_sync #(.N(DW)) u_sact_back (.clk(hclk), .rst_n(rst_n), .d(sact_d),    .q(sact_h));
  vpp_sync #(.N(1))  u_done_back (.clk(hclk), .rst_n(rst_n), .d(done_tog),  .q(done_s));

  vpp_tog_rx u_sval_rx  (.clk(dclk), .rst_n(rst_n), .tog(sval_tog),  .pulse(sval_p));
  vpp_tog_rx u_start_rx (.clk(dclk), .rst_n(rst_n), .tog(start_tog), .pulse(start_p));
  vpp_tog_rx u_sclr_rx  (.clk(dclk), .rst_n(rst_n), .tog(sclr_tog),  .pulse(sclr_p));

  vpp_player #(.W(W), .STEPS(STEPS)) u_play (
    .clk(dclk), .rst_n(rst_n), .start(start_p), .sval_load(sval_p), .sval(sval_r),
    .pat(pat_flat), .sout(sout), .done_tog(done_tog));

  AST_READ_LATENCY: assert property (@(posedge hclk) disable iff (!rst_n)
    host_rd |=> host_rvalid); // R10

  AST_START_BLOCKED: assert property (@(posedge hclk) disable iff (!rst_n)
    (busy && host_wr && host_addr == A_CTRL) |=> $stable(start_tog)); // R5

  AST_AOUT_HOLD: assert property (@(posedge hclk) disable iff (!rst_n)
    !(host_wr && host_addr == A_AOUT) |=> $stable(aout)); // R2
endmodule

// File: tb/test_virt_probe_port.sv
`timescale 1ns/1ps
module test_virt_probe_port;
  localparam int W  = 4;
  localparam int DW = 2 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [4:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic host_rvalid;
  logic [W-1:0] aout, sout;
  logic [W-1:0] ain = '0, sin = '0;

  always #2 clk = ~clk;

  virt_probe_port #(.W(W)) i_virt_probe_port (
    .hclk(clk), .dclk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .aout(aout), .ain(ain), .sout(sout), .sin(sin));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    int         due;
    logic [W-1:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares sout against queued expectations on their due cycle
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      if (it.due < cyc) check({it.tag, " (missed cycle)"}, 8'hxx, 8'h00);
      else check(it.tag, {{W{1'b0}}, sout}, {{W{1'b0}}, it.exp});
    end
  end

  task automatic push(int due, logic [W-1:0] exp, string tag);
    item_t it;
    it.due = due; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic host_write(logic [4:0] a, logic [DW-1:0] d, output int n0);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    n0 = cyc;
  endtask

  task automatic host_read(logic [4:0] a, output logic [DW-1:0] d, output logic v);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata; v = host_rvalid;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [W-1:0] patv(int k);
    return W'(k * 7 + 3);
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    int n0, n1;
    logic [DW-1:0] rd;
    logic rv;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    check("R1 sout", {{W{1'b0}}, sout}, '0);
    check("R1 aout", {{W{1'b0}}, aout}, '0);
    check("R1 rvalid", {{(DW-1){1'b0}}, host_rvalid}, '0);
    host_read(5'd2, rd, rv); check("R1 busy", rd, '0);
    host_read(5'd5, rd, rv); check("R1 async flags", rd, '0);
    host_read(5'd6, rd, rv); check("R1 sync flags", rd, '0);

    // R2 asynchronous output
    host_write(5'd0, 8'h0A, n0);
    check("R2 aout after write", {{W{1'b0}}, aout}, 8'h0A);
    idle(3);
    check("R2 aout held", {{W{1'b0}}, aout}, 8'h0A);

    // R3 static synchronous value
    host_write(5'd1, 8'h05, n0);
    push(n0 + 3, 4'h0, "R3 sout before latency");
    push(n0 + 4, 4'h5, "R3 sout static");
    while (sbq.size() > 0) @(negedge clk);

    // R4 pattern load and read back (R10)
    for (int k = 0; k < 16; k++) host_write(5'(16 + k), {{W{1'b0}}, patv(k)}, n1);
    host_read(5'd23, rd, rv);
    check("R10 pattern readback", rd, {{W{1'b0}}, patv(7)});
    check("R10 rvalid", {{(DW-1){1'b0}}, rv}, 8'h01);
    host_read(5'd7, rd, rv);
    check("R10 unmapped reads zero", rd, '0);

    // R4 playback, R5 busy and blocked restart
    host_write(5'd2, 8'h01, n0);
    for (int k = 0; k < 16; k++) push(n0 + 3 + k, patv(k), $sformatf("R4 step %0d", k));
    push(n0 + 19, 4'h5, "R4 static after playback");
    for (int c = 20; c <= 24; c++) push(n0 + c, 4'h5, "R5 restart during busy ignored");
    host_read(5'd2, rd, rv);
    check("R5 busy during playback", rd, 8'h01);
    host_write(5'd2, 8'h01, n1);
    while (sbq.size() > 0) @(negedge clk);
    host_read(5'd2, rd, rv);
    check("R5 busy cleared", rd, '0);

    // R6 / R7 synchronous input and activity
    sin = 4'hC;
    idle(6);
    host_read(5'd4, rd, rv); check("R6 sin readback", rd, 8'h0C);
    host_read(5'd6, rd, rv); check("R7 rise flags", rd, 8'h0C);
    host_write(5'd6, 8'hFF, n0);
    idle(6);
    host_read(5'd6, rd, rv); check("R8 full clear", rd, '0);

    // R7 single-cycle glitch on bit 0
    @(negedge clk); sin = 4'hD;
    @(negedge clk); sin = 4'hC;
    idle(6);
    host_read(5'd6, rd, rv); check("R7 glitch sets rise and fall", rd, 8'h11);

    // R8 partial mask keeps unmasked bits
    host_write(5'd6, 8'h0F, n0);
    idle(6);
    host_read(5'd6, rd, rv); check("R8 masked clear", rd, 8'h10);

    // R8 edge arriving with the clear survives
    host_write(5'd6, 8'hFF, n0);
    @(negedge clk);
    @(negedge clk);
    sin = 4'hE;
    idle(6);
    host_read(5'd6, rd, rv); check("R8 edge during clear kept", rd, 8'h02);

    // R9 asynchronous input and activity
    ain = 4'h3;
    idle(5);
    host_read(5'd3, rd, rv); check("R9 ain readback", rd, 8'h03);
    host_read(5'd5, rd, rv); check("R9 async rise flags", rd, 8'h03);
    host_write(5'd5, 8'h0F, n0);
    ain = 4'h0;
    idle(5);
    host_read(5'd5, rd, rv); check("R9 async clear then fall", rd, 8'h30);

    idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule